// File: doc/BRIEF.md
# Fractional-N Quad-Modulus Divider Control

This block steers the feedback divider of a fractional-N frequency synthesizer. The divider is built around an external prescaler with four division moduli: P, P+1, P+4 and P+5. The block is clocked by the prescaler output. In every prescaler cycle it chooses the modulus for the next division. It also marks the end of each complete divided period with a one-cycle pulse, which goes to the phase detector.

The requested ratio has three inputs: an integer value, a fractional numerator and a choice of fractional modulus, 15 or 16. The block splits the integer ratio into a main count B, a four-step swallow count C and a one-step swallow count A, so that N = P·B + 4·C + A. A first-order accumulator adds the numerator once per period. On each period in which it wraps, that period's ratio is one higher. Over time the average ratio becomes N + num/modulus. Choosing modulus 15 or 16 gives the denominators 1, 2, 3, 4, 5, 8, 15 and 16. There are two prescaler bands. The high band uses P = 16 (moduli 16/17/20/21). The low band uses P = 8 (moduli 8/9/12/13).

Top module: `fracn_divctl`

## Requirements
- R1: `mod_sel` encodes the modulus for the current prescaler cycle: 00 = P, 01 = P+1, 10 = P+4, 11 = P+5. P is 16 when `band_hi` = 1 and 8 when `band_hi` = 0. The moduli selected during one period add up to that period's effective ratio.
- R2: Within a period, P+5 is used while both swallow counts remain. Next comes P+4 while only C remains, or P+1 while only A remains, and then P. The code never returns to 11 after leaving it, and never leaves 00 before the period ends.
- R3: An integer request below the band minimum is raised to that minimum. The minimum is 80 in the high band and 40 in the low band.
- R4: An integer request above the band maximum is lowered to that maximum. The maximum is 32767 in the high band and 16383 in the low band.
- R5: Every period has ratio N or N+1. Starting from reset, any run of M consecutive periods (M = modulus) adds up to M·N + num.
- R6: `frac_mod16` = 1 selects accumulator modulus 16 and 0 selects 15. A numerator at or above the modulus is treated as modulus − 1.
- R7: Changes to `band_hi`, `n_int`, `frac_num` or `frac_mod16` take effect only at the start of the next period. The period in progress keeps its ratio.
- R8: `div_pulse` is high for exactly one input clock, in the last prescaler cycle of each period. A period of ratio R lasts R >> log2(P) prescaler cycles.
- R9: While `rst_n` is low, `div_pulse` = 0 and `mod_sel` = 00. The first prescaler cycle after reset release is idle (modulus P, no pulse), and the first period starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| band_hi | input | 1 | 1: P = 16 band, 0: P = 8 band |
| n_int | input | 15 | Integer divide request |
| frac_num | input | 4 | Fractional numerator |
| frac_mod16 | input | 1 | 1: modulus 16, 0: modulus 15 |
| mod_sel | output | 2 | Prescaler modulus select for this cycle |
| div_pulse | output | 1 | One-cycle pulse ending each divided period |

## Verification
A wrong swallow counter shows up in the first period after the fault as a period total off by 1 or 4. It can also show up as a select code out of order, for example a return to P+5 after plain P. A wrong main counter shifts the pulse by whole prescaler cycles in the same period. A fault in the accumulator is harder to see, because each single period can still look legal at N or N+1. It only appears when a full run of 15 or 16 periods is added up, and the bench therefore always measures a complete accumulator cycle from reset.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    typedef enum logic [1:0] {
        SEL_P  = 2'b00,
        SEL_P1 = 2'b01,
        SEL_P4 = 2'b10,
        SEL_P5 = 2'b11
    } msel_e;
endpackage

// File: rtl/fracn_ratio_clamp.sv
module fracn_ratio_clamp #(
    parameter int NW     = 15,
    parameter int FW     = 4,
    parameter int MIN_HI = 80,
    parameter int MIN_LO = 40,
    parameter int MAX_HI = 32767,
    parameter int MAX_LO = 16383
) (
    input  logic          band_hi,
    input  logic [NW-1:0] n_req,
    input  logic [FW-1:0] num_req,
    input  logic          mod16,
    output logic [NW-1:0] n_ok,
    output logic [FW-1:0] num_ok,
    output logic [FW:0]   modulus
);
    localparam logic [NW-1:0] LO_HI = NW'(MIN_HI);
    localparam logic [NW-1:0] LO_LO = NW'(MIN_LO);
    localparam logic [NW-1:0] HI_HI = NW'(MAX_HI);
    localparam logic [NW-1:0] HI_LO = NW'(MAX_LO);

    logic [NW-1:0] lim_min, lim_max;

    always_comb begin
        lim_min = band_hi ? LO_HI : LO_LO;
        lim_max = band_hi ? HI_HI : HI_LO;
        // R3 / R4: keep the integer request inside the continuous range
        if (n_req < lim_min)      n_ok = lim_min;
        else if (n_req > lim_max) n_ok = lim_max;
        else                      n_ok = n_req;
        // R6: modulus choice and numerator limit
        modulus = mod16 ? (FW+1)'(16) : (FW+1)'(15);
        if ({1'b0, num_req} >= modulus) num_ok = FW'(modulus - 1'b1);
        else                            num_ok = num_req;
    end
endmodule

// File: rtl/fracn_frac_acc.sv
module fracn_frac_acc #(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [FW-1:0] num,
    input  logic [FW:0]   modulus,
    output logic          carry
);
    typedef struct packed {
        logic [FW-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [FW:0] sum;

    always_comb begin
        st_d  = st_q;
        sum   = {1'b0, st_q.acc} + {1'b0, num};
        carry = (sum >= modulus);
        if (load) begin
            st_d.acc = carry ? FW'(sum - modulus) : FW'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: after a wrap the residue is smaller than the numerator that caused it
    assert_wrap_residue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && carry && ({1'b0, st_q.acc} < modulus)) |=> (st_q.acc < $past(num)));
endmodule

// File: rtl/fracn_swallow_ctr.sv
module fracn_swallow_ctr #(
    parameter int NW       = 15,
    parameter int CW       = 13,
    parameter int PHI_LOG2 = 4,
    parameter int PLO_LOG2 = 3,
    parameter int MIN_B    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        band_hi,
    input  logic [NW:0] n_eff,
    output logic        load,
    output logic [1:0]  mod_sel,
    output logic        pulse
);
    import fracn_pkg::*;

    typedef struct packed {
        logic          start;
        logic [CW-1:0] cnt;
        logic [1:0]    a_rem;
        logic [1:0]    c_rem;
    } ctr_st_t;

    ctr_st_t     st_d, st_q;
    logic [NW:0] b_full;
    logic [NW:0] rem;
    logic [NW:0] rem_mask;
    msel_e       sel;

    always_comb begin
        if (band_hi) begin
            b_full   = n_eff >> PHI_LOG2;
            rem_mask = (NW+1)'((1 << PHI_LOG2) - 1);
        end else begin
            b_full   = n_eff >> PLO_LOG2;
            rem_mask = (NW+1)'((1 << PLO_LOG2) - 1);
        end
        rem = n_eff & rem_mask;

        pulse = !st_q.start && (st_q.cnt == '0);
        load  = st_q.start || (st_q.cnt == '0);

        unique case ({st_q.c_rem != 2'd0, st_q.a_rem != 2'd0})
            2'b11:   sel = SEL_P5;
            2'b10:   sel = SEL_P4;
            2'b01:   sel = SEL_P1;
            default: sel = SEL_P;
        endcase
        mod_sel = sel;

        st_d       = st_q;
        st_d.start = 1'b0;
        if (load) begin
            st_d.cnt   = CW'(b_full - 1'b1);
            st_d.a_rem = rem[1:0];
            st_d.c_rem = rem[3:2];
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.a_rem != 2'd0) st_d.a_rem = st_q.a_rem - 2'd1;
            if (st_q.c_rem != 2'd0) st_d.c_rem = st_q.c_rem - 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.start <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: plain P is never left before the period ends
    assert_sel_stays_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.start && !pulse && mod_sel == 2'b00) |=> (mod_sel == 2'b00));
    // R2: P+5 is never re-entered within a period
    assert_no_reenter_p5_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.start && !pulse && mod_sel != 2'b11) |=> (mod_sel != 2'b11));
    // R8: the end-of-period pulse lasts one clock
    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R3: every loaded period is at least the minimum main count long
    assert_min_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.cnt >= CW'(MIN_B - 1)));
    // R1: swallow counts are used up before the period closes
    assert_swallow_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.a_rem != 2'd0 || st_q.c_rem != 2'd0) |-> !pulse);
endmodule

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
    parameter int NW       = 15,
    parameter int FW       = 4,
    parameter int PHI_LOG2 = 4,
    parameter int PLO_LOG2 = 3,
    parameter int MIN_HI   = 80,
    parameter int MIN_LO   = 40,
    parameter int MAX_HI   = 32767,
    parameter int MAX_LO   = 16383
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          band_hi,
    input  logic [NW-1:0] n_int,
    input  logic [FW-1:0] frac_num,
    input  logic          frac_mod16,
    output logic [1:0]    mod_sel,
    output logic          div_pulse
);
    localparam int CW     = NW + 1 - PLO_LOG2;
    localparam int MINB_H = MIN_HI >> PHI_LOG2;
    localparam int MINB_L = MIN_LO >> PLO_LOG2;
    localparam int MIN_B  = (MINB_H < MINB_L) ? MINB_H : MINB_L;

    logic [NW-1:0] n_ok;
    logic [FW-1:0] num_ok;
    logic [FW:0]   modulus;
    logic          carry;
    logic          load;
    logic [NW:0]   n_eff;

    fracn_ratio_clamp #(
        .NW(NW), .FW(FW), .MIN_HI(MIN_HI), .MIN_LO(MIN_LO),
        .MAX_HI(MAX_HI), .MAX_LO(MAX_LO)
    ) clamp_i (
        .band_hi (band_hi),
        .n_req   (n_int),
        .num_req (frac_num),
        .mod16   (frac_mod16),
        .n_ok    (n_ok),
        .num_ok  (num_ok),
        .modulus (modulus)
    );

    fracn_frac_acc #(.FW(FW)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .num     (num_ok),
        .modulus (modulus),
        .carry   (carry)
    );

    assign n_eff = {1'b0, n_ok} + {{NW{1'b0}}, carry};

    fracn_swallow_ctr #(
        .NW(NW), .CW(CW), .PHI_LOG2(PHI_LOG2), .PLO_LOG2(PLO_LOG2), .MIN_B(MIN_B)
    ) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .band_hi (band_hi),
        .n_eff   (n_eff),
        .load    (load),
        .mod_sel (mod_sel),
        .pulse   (div_pulse)
    );
endmodule

// File: tb/fracn_divctl_tb_top.sv
`timescale 1ns/1ps
module fracn_divctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        band_hi = 1'b1;
    logic [14:0] n_int = 15'd1000;
    logic [3:0]  frac_num = 4'd0;
    logic        frac_mod16 = 1'b1;
    logic [1:0]  mod_sel;
    logic        div_pulse;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    fracn_divctl dut_i (
        .clk(clk), .rst_n(rst_n), .band_hi(band_hi), .n_int(n_int),
        .frac_num(frac_num), .frac_mod16(frac_mod16),
        .mod_sel(mod_sel), .div_pulse(div_pulse)
    );

    typedef struct packed {
        logic        hi;
        logic [14:0] n;
        logic [3:0]  f;
        logic        m16;
        logic [14:0] exp_n;
        logic [3:0]  exp_f;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 15'd1000,  4'd0,  1'b1, 15'd1000,  4'd0},
        '{1'b1, 15'd1000,  4'd5,  1'b1, 15'd1000,  4'd5},
        '{1'b1, 15'd1000,  4'd7,  1'b0, 15'd1000,  4'd7},
        '{1'b0, 15'd500,   4'd3,  1'b1, 15'd500,   4'd3},
        '{1'b1, 15'd50,    4'd1,  1'b1, 15'd80,    4'd1},
        '{1'b0, 15'd20,    4'd0,  1'b1, 15'd40,    4'd0},
        '{1'b0, 15'd20000, 4'd2,  1'b0, 15'd16383, 4'd2},
        '{1'b1, 15'd2003,  4'd15, 1'b0, 15'd2003,  4'd14},
        '{1'b1, 15'd32767, 4'd0,  1'b1, 15'd32767, 4'd0},
        '{1'b0, 15'd333,   4'd9,  1'b0, 15'd333,   4'd9}
    };

    function automatic int sel_add(input logic [1:0] s);
        case (s)
            2'b01:   return 1;
            2'b10:   return 4;
            2'b11:   return 5;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0 && mod_sel == 2'b00, "R9 reset outputs",
              {29'd0, div_pulse, mod_sel}, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        // table walk: R1 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            int p, np, tot, cyc, grand, bad_rng, bad_cyc, bad_ord, dbl;
            logic [1:0] prev_sel;
            logic prev_pulse;
            band_hi = VECS[v].hi; n_int = VECS[v].n;
            frac_num = VECS[v].f; frac_mod16 = VECS[v].m16;
            do_reset();
            p = VECS[v].hi ? 16 : 8;
            np = VECS[v].m16 ? 16 : 15;
            tot = 0; cyc = 0; grand = 0; bad_rng = 0; bad_cyc = 0; bad_ord = 0; dbl = 0;
            prev_sel = 2'b00; prev_pulse = 1'b0;
            for (int k = 0; k < np; ) begin
                @(negedge clk);
                tot += p + sel_add(mod_sel);
                cyc++;
                if (cyc > 1 && prev_sel == 2'b00 && mod_sel != 2'b00) bad_ord++;
                if (cyc > 1 && prev_sel != 2'b11 && mod_sel == 2'b11) bad_ord++;
                if (prev_pulse && div_pulse) dbl++;
                prev_sel = mod_sel;
                prev_pulse = div_pulse;
                if (div_pulse) begin
                    if (tot != int'(VECS[v].exp_n) && tot != int'(VECS[v].exp_n) + 1) bad_rng++;
                    if (cyc != (tot / p)) bad_cyc++;
                    grand += tot;
                    tot = 0; cyc = 0;
                    k++;
                end
            end
            check(grand == np * int'(VECS[v].exp_n) + int'(VECS[v].exp_f),
                  "R5 R3 R4 R6 accumulated total", grand,
                  np * int'(VECS[v].exp_n) + int'(VECS[v].exp_f));
            check(bad_rng == 0, "R1 period ratio N or N+1", bad_rng, 0);
            check(bad_cyc == 0 && dbl == 0, "R8 period length and pulse width", bad_cyc + dbl, 0);
            check(bad_ord == 0, "R2 select order", bad_ord, 0);
        end

        // R2 directed: high band N=1019 -> B=63, C=2, A=3 -> 11,11,01,00
        begin
            logic [1:0] seq [4];
            band_hi = 1'b1; n_int = 15'd1019; frac_num = 4'd0; frac_mod16 = 1'b1;
            do_reset();
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                seq[i] = mod_sel;
            end
            check(seq[0] == 2'b11 && seq[1] == 2'b11 && seq[2] == 2'b01 && seq[3] == 2'b00,
                  "R2 swallow sequence", {24'd0, seq[0], seq[1], seq[2], seq[3]}, 8'b11110100);
        end

        // R7 directed: change request mid-period; current period keeps 1000
        begin
            int tot, per, got0, got1;
            band_hi = 1'b1; n_int = 15'd1000; frac_num = 4'd0; frac_mod16 = 1'b1;
            do_reset();
            tot = 0; per = 0; got0 = 0; got1 = 0;
            for (int c = 0; per < 2; c++) begin
                @(negedge clk);
                tot += 16 + sel_add(mod_sel);
                if (c == 10) n_int = 15'd2000;
                if (div_pulse) begin
                    if (per == 0) got0 = tot; else got1 = tot;
                    tot = 0; per++;
                end
            end
            check(got0 == 1000, "R7 period in progress unchanged", got0, 1000);
            check(got1 == 2000, "R7 new ratio at next period", got1, 2000);
        end

        // R9 directed: first period begins one cycle after reset release
        begin
            int cyc;
            band_hi = 1'b0; n_int = 15'd40; frac_num = 4'd0; frac_mod16 = 1'b1;
            do_reset();
            cyc = 0;
            for (int c = 0; c < 5; c++) begin
                @(negedge clk);
                cyc++;
                if (div_pulse) break;
            end
            check(cyc == 5, "R9 idle cycle then first period of 5", cyc, 5);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule